// File: doc/BRIEF.md
# User Interprocessor Interrupt Sender

This block carries out one complete user interprocessor interrupt send, starting from a table index. It first checks that the feature is enabled and that the index lies inside the configured target table. It then fetches the two 64-bit words of the selected 16-byte table entry and validates the first word. From the second word it takes the address of a posted-interrupt descriptor and reads both of the descriptor's words under a memory lock. It rejects descriptors that have reserved bits set. It sets the posted-request bit chosen by the entry's user vector, decides whether a notification is needed and writes the descriptor back, which releases the lock.

When a notification is needed, the block raises a one-cycle ordinary interrupt request. That request carries the descriptor's notification vector and a destination whose format depends on the interrupt-controller addressing mode. Each send ends with a one-cycle done pulse or a one-cycle fault pulse with a fault class. Only one send is handled at a time.

Top module: `uipi_sender`

## Requirements
- R1: If any of `cfg_uint_en`, `cfg_tt_en` or `cpu_64b` is 0, or `in_enclave` is 1, a start gives `fault` with `fault_kind` = 2'b01 (invalid opcode) in the cycle after start, and no memory access is made.
- R2: If `index` is greater than `tbl_size`, a start gives `fault` with `fault_kind` = 2'b10 (general protection, error code 0) in the cycle after start, with no memory access. An index equal to `tbl_size` is accepted.
- R3: The entry is read at `tbl_base + index*16` (bit 0 valid, bits 7:1 reserved, bits 15:8 user vector), then at that address + 8 (descriptor address in the low `AW` bits).
- R4: If the entry's valid bit is 0 or any of its bits 7:1 is 1, the send ends with a general-protection fault after that single read, and the descriptor is not touched.
- R5: If control word bits 15:2 or 31:24 of the descriptor are nonzero, the send ends with a general-protection fault, no write is made, and `mem_lock` is low when `fault` is seen.
- R6: The descriptor's second word (at descriptor address + 8) is written back with bit `uv[5:0]` set and all other bits unchanged.
- R7: In the descriptor control word, bit 0 is outstanding and bit 1 is suppress. When both are 0, the control word is written back with bit 0 set and a notification is raised. Otherwise the control word is written back unchanged and no notification is raised.
- R8: A notification is an `ipi_valid` pulse in the same cycle as `done`. `ipi_vec` is control bits 23:16. When `x2_mode` = 1, `ipi_dst` is control bits 63:32. Otherwise it is control bits 47:40, zero-extended.
- R9: `mem_lock` is high for every descriptor read and write of a send, and it is low once `done` or `fault` is seen.
- R10: Every memory request is marked supervisor (`mem_sup` = 1), whatever the privilege of the requester.
- R11: A start while `busy` is ignored. `done` and `fault` are single-cycle pulses and are never high together.
- R12: After reset, `busy`, `mem_req`, `done`, `fault` and `ipi_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a send (taken only when idle) |
| index | input | IDXW | Target table index |
| tbl_base | input | AW | Target table base address |
| tbl_size | input | IDXW | Highest permitted index |
| cfg_uint_en | input | 1 | Feature enable control bit |
| cfg_tt_en | input | 1 | Target table enable (configuration bit 0) |
| cpu_64b | input | 1 | Processor is in 64-bit mode |
| in_enclave | input | 1 | Execution is inside an enclave |
| x2_mode | input | 1 | Extended interrupt-controller addressing mode |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Locked access sequence in progress |
| mem_sup | output | 1 | Request made with supervisor privilege |
| mem_addr | output | AW | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| ipi_valid | output | 1 | Ordinary interrupt request pulse |
| ipi_vec | output | 8 | Notification vector |
| ipi_dst | output | 32 | Destination identifier |
| busy | output | 1 | Send in progress |
| done | output | 1 | Send finished without fault (pulse) |
| fault | output | 1 | Send aborted (pulse) |
| fault_kind | output | 2 | 2'b01 invalid opcode, 2'b10 general protection |

## Verification
Configuration and index faults are registered at the edge that takes `start`, so they are due exactly one cycle later, and the bench checks that latency directly. Every other result depends on how many memory handshakes come before it. The bench therefore counts acknowledged accesses and writes: 1 access for an entry fault, 3 for a descriptor fault, 6 with 2 writes for a success. It polls on falling edges until `done` or `fault` appears and samples all result ports in that same cycle. Lock, supervisor marking and single-pulse behaviour are watched on every falling edge for the whole run.

// File: rtl/uipi_pkg.sv
package uipi_pkg;
  localparam int WORD_W   = 64;
  localparam int ENT_SHFT = 4;
  localparam int HALF_OFS = 8;
  localparam int PIR_W    = 64;
  localparam int PIR_SELW = $clog2(PIR_W);

  // control word of the descriptor
  localparam int C_OUT    = 0;
  localparam int C_SUP    = 1;
  localparam int C_VEC_LO = 16;
  localparam int C_DST_LO = 32;
  localparam int C_DS8_LO = 40;

  // first word of the target entry
  localparam int E_VALID  = 0;
  localparam int E_UV_LO  = 8;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_UD   = 2'b01,
    FLT_GP   = 2'b10
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENT0,
    S_ENT1,
    S_DSC0,
    S_DSC1,
    S_WR1,
    S_WR0
  } state_e;
endpackage

// File: rtl/uipi_gate.sv
module uipi_gate #(
  parameter int IDXW = 16
) (
  input  logic            cfg_uint_en,
  input  logic            cfg_tt_en,
  input  logic            cpu_64b,
  input  logic            in_enclave,
  input  logic [IDXW-1:0] index,
  input  logic [IDXW-1:0] tbl_size,
  output logic            ud_fault,
  output logic            idx_bad
);
  logic allowed;

  always_comb begin
    allowed  = cfg_uint_en & cfg_tt_en & cpu_64b & ~in_enclave;
    ud_fault = ~allowed;
    idx_bad  = (index > tbl_size);
  end
endmodule

// File: rtl/uipi_entry_chk.sv
module uipi_entry_chk
  import uipi_pkg::*;
(
  input  logic [WORD_W-1:0] ent_word,
  output logic              ent_ok,
  output logic [7:0]        ent_uv
);
  logic rsv_set;

  always_comb begin
    rsv_set = |ent_word[E_VALID+7:E_VALID+1];
    ent_ok  = ent_word[E_VALID] & ~rsv_set;
    ent_uv  = ent_word[E_UV_LO +: 8];
  end
endmodule

// File: rtl/uipi_desc_upd.sv
module uipi_desc_upd
  import uipi_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [PIR_W-1:0]  pir_word,
  input  logic [7:0]        uv,
  input  logic              x2_mode,
  output logic              resv_bad,
  output logic              notify,
  output logic [WORD_W-1:0] ctl_new,
  output logic [PIR_W-1:0]  pir_new,
  output logic [7:0]        note_vec,
  output logic [31:0]       note_dst
);
  logic [PIR_SELW-1:0] sel;

  assign sel = uv[PIR_SELW-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < PIR_W; gi++) begin : g_pir
      assign pir_new[gi] = pir_word[gi] | (sel == PIR_SELW'(gi));
    end
  endgenerate

  always_comb begin
    resv_bad = (|ctl_word[15:2]) | (|ctl_word[31:24]);
    notify   = ~ctl_word[C_SUP] & ~ctl_word[C_OUT];
    ctl_new  = ctl_word;
    ctl_new[C_OUT] = ctl_word[C_OUT] | notify;
    note_vec = ctl_word[C_VEC_LO +: 8];
    if (x2_mode) note_dst = ctl_word[C_DST_LO +: 32];
    else         note_dst = {24'd0, ctl_word[C_DS8_LO +: 8]};
  end
endmodule

// File: rtl/uipi_ctrl.sv
module uipi_ctrl
  import uipi_pkg::*;
#(
  parameter int AW   = 48,
  parameter int IDXW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDXW-1:0]   index,
  input  logic [AW-1:0]     tbl_base,
  input  logic              ud_fault,
  input  logic              idx_bad,
  input  logic              ent_ok,
  input  logic [7:0]        ent_uv,
  input  logic              resv_bad,
  input  logic              notify,
  input  logic [WORD_W-1:0] ctl_new,
  input  logic [PIR_W-1:0]  pir_new,
  input  logic [7:0]        note_vec,
  input  logic [31:0]       note_dst,
  output logic [WORD_W-1:0] ctl_sel,
  output logic [PIR_W-1:0]  pir_q_o,
  output logic [7:0]        uv_q_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic              mem_sup,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ipi_valid,
  output logic [7:0]        ipi_vec,
  output logic [31:0]       ipi_dst,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_kind
);
  state_e            state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [7:0]        uv_q, uv_d;
  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic [PIR_W-1:0]  pir_q, pir_d;
  logic              done_d, fault_d, ipi_d;
  fault_e            kind_q, kind_d;
  logic [7:0]        vec_q, vec_d;
  logic [31:0]       dst_q, dst_d;
  logic              res_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    uv_d    = uv_q;
    ctl_d   = ctl_q;
    pir_d   = pir_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    ipi_d   = 1'b0;
    kind_d  = FLT_NONE;
    vec_d   = vec_q;
    dst_d   = dst_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          if (ud_fault) begin
            fault_d = 1'b1;
            kind_d  = FLT_UD;
          end else if (idx_bad) begin
            fault_d = 1'b1;
            kind_d  = FLT_GP;
          end else begin
            addr_d  = tbl_base + (AW'(index) << ENT_SHFT);
            state_d = S_ENT0;
          end
        end
      end
      S_ENT0: begin
        if (mem_ack) begin
          if (!ent_ok) begin
            fault_d = 1'b1;
            kind_d  = FLT_GP;
            state_d = S_IDLE;
          end else begin
            uv_d    = ent_uv;
            addr_d  = addr_q + AW'(HALF_OFS);
            state_d = S_ENT1;
          end
        end
      end
      S_ENT1: begin
        if (mem_ack) begin
          addr_d  = mem_rdata[AW-1:0];
          state_d = S_DSC0;
        end
      end
      S_DSC0: begin
        if (mem_ack) begin
          if (resv_bad) begin
            fault_d = 1'b1;
            kind_d  = FLT_GP;
            state_d = S_IDLE;
          end else begin
            ctl_d   = mem_rdata;
            addr_d  = addr_q + AW'(HALF_OFS);
            state_d = S_DSC1;
          end
        end
      end
      S_DSC1: begin
        if (mem_ack) begin
          pir_d   = mem_rdata;
          state_d = S_WR1;
        end
      end
      S_WR1: begin
        if (mem_ack) begin
          addr_d  = addr_q - AW'(HALF_OFS);
          state_d = S_WR0;
        end
      end
      S_WR0: begin
        if (mem_ack) begin
          done_d  = 1'b1;
          ipi_d   = notify;
          vec_d   = note_vec;
          dst_d   = note_dst;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign res_en = done_d | (state_q == S_IDLE && start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      uv_q    <= '0;
      ctl_q   <= '0;
      pir_q   <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
      ipi_valid <= 1'b0;
      kind_q  <= FLT_NONE;
      vec_q   <= '0;
      dst_q   <= '0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      uv_q      <= uv_d;
      ctl_q     <= ctl_d;
      pir_q     <= pir_d;
      done      <= done_d;
      fault     <= fault_d;
      ipi_valid <= ipi_d;
      kind_q    <= kind_d;
      if (res_en) begin
        vec_q <= vec_d;
        dst_q <= dst_d;
      end
    end
  end

  always_comb begin
    mem_req   = (state_q != S_IDLE);
    mem_we    = (state_q == S_WR1) || (state_q == S_WR0);
    mem_lock  = (state_q == S_DSC0) || (state_q == S_DSC1) ||
                (state_q == S_WR1)  || (state_q == S_WR0);
    mem_sup   = mem_req;
    mem_addr  = addr_q;
    mem_wdata = (state_q == S_WR1) ? pir_new : ctl_new;
    ctl_sel   = (state_q == S_DSC0) ? mem_rdata : ctl_q;
    pir_q_o   = pir_q;
    uv_q_o    = uv_q;
    busy      = (state_q != S_IDLE);
    ipi_vec   = vec_q;
    ipi_dst   = dst_q;
    fault_kind = kind_q;
  end

  // R11: single-cycle, mutually exclusive completion
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  // R1: configuration fault one cycle after an accepted start
  p_cfg_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ud_fault) |=> (fault && fault_kind == FLT_UD && !mem_req));
  // R8: notification only together with completion
  p_ipi_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid |-> done);
  // R9: writes happen only under the lock, lock gone at completion
  p_wr_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock);
  p_unlock_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !mem_lock);
  // R3: address held while a request waits
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: rtl/uipi_sender.sv
module uipi_sender
  import uipi_pkg::*;
#(
  parameter int AW   = 48,
  parameter int IDXW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDXW-1:0]   index,
  input  logic [AW-1:0]     tbl_base,
  input  logic [IDXW-1:0]   tbl_size,
  input  logic              cfg_uint_en,
  input  logic              cfg_tt_en,
  input  logic              cpu_64b,
  input  logic              in_enclave,
  input  logic              x2_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic              mem_sup,
  output logic [AW-1:0]     mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              ipi_valid,
  output logic [7:0]        ipi_vec,
  output logic [31:0]       ipi_dst,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_kind
);
  logic              ud_fault, idx_bad, ent_ok, resv_bad, notify;
  logic [7:0]        ent_uv, uv_q, note_vec;
  logic [31:0]       note_dst;
  logic [WORD_W-1:0] ctl_sel, ctl_new;
  logic [PIR_W-1:0]  pir_q, pir_new;

  uipi_gate #(.IDXW(IDXW)) u_gate (
    .cfg_uint_en (cfg_uint_en),
    .cfg_tt_en   (cfg_tt_en),
    .cpu_64b     (cpu_64b),
    .in_enclave  (in_enclave),
    .index       (index),
    .tbl_size    (tbl_size),
    .ud_fault    (ud_fault),
    .idx_bad     (idx_bad)
  );

  uipi_entry_chk u_ent (
    .ent_word (mem_rdata),
    .ent_ok   (ent_ok),
    .ent_uv   (ent_uv)
  );

  uipi_desc_upd u_dsc (
    .ctl_word (ctl_sel),
    .pir_word (pir_q),
    .uv       (uv_q),
    .x2_mode  (x2_mode),
    .resv_bad (resv_bad),
    .notify   (notify),
    .ctl_new  (ctl_new),
    .pir_new  (pir_new),
    .note_vec (note_vec),
    .note_dst (note_dst)
  );

  uipi_ctrl #(.AW(AW), .IDXW(IDXW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .index      (index),
    .tbl_base   (tbl_base),
    .ud_fault   (ud_fault),
    .idx_bad    (idx_bad),
    .ent_ok     (ent_ok),
    .ent_uv     (ent_uv),
    .resv_bad   (resv_bad),
    .notify     (notify),
    .ctl_new    (ctl_new),
    .pir_new    (pir_new),
    .note_vec   (note_vec),
    .note_dst   (note_dst),
    .ctl_sel    (ctl_sel),
    .pir_q_o    (pir_q),
    .uv_q_o     (uv_q),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .mem_sup    (mem_sup),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .ipi_valid  (ipi_valid),
    .ipi_vec    (ipi_vec),
    .ipi_dst    (ipi_dst),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_kind (fault_kind)
  );
endmodule

// File: tb/uipi_sender_test.sv
module uipi_sender_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int IDXW = 16;
  localparam logic [AW-1:0] TBASE = 48'h100;
  localparam logic [AW-1:0] DSC_A = 48'h400;
  localparam logic [AW-1:0] DSC_B = 48'h440;

  logic clk, rst_n, start;
  logic [IDXW-1:0] index, tbl_size;
  logic [AW-1:0] tbl_base;
  logic cfg_uint_en, cfg_tt_en, cpu_64b, in_enclave, x2_mode;
  logic mem_req, mem_we, mem_lock, mem_sup, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic ipi_valid, busy, done, fault;
  logic [7:0] ipi_vec;
  logic [31:0] ipi_dst;
  logic [1:0] fault_kind;

  logic [63:0] mem [256];
  int checks = 0, fails = 0;
  int acc_cnt = 0, wr_cnt = 0, lock_err = 0, sup_err = 0, done_cnt = 0, fault_cnt = 0;
  int cyc_total = 0;
  logic [AW-1:0] first_addr;
  logic first_seen;
  int lat;

  uipi_sender #(.AW(AW), .IDXW(IDXW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .index(index), .tbl_base(tbl_base),
    .tbl_size(tbl_size), .cfg_uint_en(cfg_uint_en), .cfg_tt_en(cfg_tt_en),
    .cpu_64b(cpu_64b), .in_enclave(in_enclave), .x2_mode(x2_mode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_sup(mem_sup),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ipi_valid(ipi_valid), .ipi_vec(ipi_vec),
    .ipi_dst(ipi_dst), .busy(busy), .done(done), .fault(fault),
    .fault_kind(fault_kind)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle registered acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      if (mem_req && mem_we && mem_ack) mem[mem_addr[10:3]] <= mem_wdata;
      mem_ack <= mem_req && !mem_ack;
    end
  end
  assign mem_rdata = mem[mem_addr[10:3]];

  // monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && !mem_sup) sup_err++;
      if (mem_req && mem_addr >= DSC_A && !mem_lock) lock_err++;
      if (mem_req && mem_ack) begin
        acc_cnt++;
        if (mem_we) wr_cnt++;
        if (!first_seen) begin first_addr = mem_addr; first_seen = 1'b1; end
      end
      if (done) done_cnt++;
      if (fault) fault_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ctl_w(input logic [31:0] dst, input logic [7:0] vec,
                                        input bit sn, input bit on);
    return {dst, 8'h00, vec, 14'h0, sn, on};
  endfunction

  task automatic set_entry(input int idx, input logic [7:0] low, input logic [7:0] uv,
                           input logic [AW-1:0] dsc);
    mem[(TBASE[10:3]) + 2*idx]     = {48'h0, uv, low};
    mem[(TBASE[10:3]) + 2*idx + 1] = {16'h0, dsc};
  endtask

  task automatic set_cfg(input bit u, input bit t, input bit m, input bit e);
    cfg_uint_en = u; cfg_tt_en = t; cpu_64b = m; in_enclave = e;
  endtask

  // issue a start, wait for done or fault; lat = cycles after start
  task automatic send(input logic [IDXW-1:0] idx);
    @(negedge clk);
    acc_cnt = 0; wr_cnt = 0; first_seen = 1'b0;
    index = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!(done || fault) && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !done && !fault && !ipi_valid, "R12 reset", {busy, mem_req, done, fault, ipi_valid}, 0);
  endtask

  task automatic t_cfg;
    for (int k = 0; k < 4; k++) begin
      set_cfg(k != 0, k != 1, k != 2, k == 3);
      send(16'd1);
      chk(fault && fault_kind == 2'b01, "R1 ud fault", {fault, fault_kind}, 3'b101);
      chk(lat == 1 && acc_cnt == 0, "R1 latency/no access", lat * 256 + acc_cnt, 256);
    end
    set_cfg(1, 1, 1, 0);
  endtask

  task automatic t_index;
    send(16'd4);
    chk(fault && fault_kind == 2'b10 && lat == 1, "R2 index above size", {fault, fault_kind, 8'(lat)}, {3'b110, 8'd1});
    chk(acc_cnt == 0, "R2 no access", acc_cnt, 0);
    set_entry(3, 8'h01, 8'd2, DSC_B);
    mem[DSC_B[10:3]] = ctl_w(32'h0000_AB00, 8'h31, 0, 0);
    mem[DSC_B[10:3] + 1] = 64'h0;
    send(16'd3);
    chk(done && !fault, "R2 index equal size accepted", {done, fault}, 2'b10);
    chk(first_addr == TBASE + 48'h30, "R3 entry address", first_addr, TBASE + 48'h30);
  endtask

  task automatic t_entry_bad;
    set_entry(0, 8'h00, 8'd1, DSC_A);
    send(16'd0);
    chk(fault && fault_kind == 2'b10 && acc_cnt == 1, "R4 invalid entry", {fault, fault_kind, 8'(acc_cnt)}, {3'b110, 8'd1});
    set_entry(0, 8'h09, 8'd1, DSC_A);
    send(16'd0);
    chk(fault && fault_kind == 2'b10 && acc_cnt == 1, "R4 reserved entry bit", {fault, fault_kind, 8'(acc_cnt)}, {3'b110, 8'd1});
  endtask

  task automatic t_resv;
    set_entry(2, 8'h01, 8'd4, DSC_A);
    mem[DSC_A[10:3]] = ctl_w(32'h1, 8'h20, 0, 0) | 64'h20;
    send(16'd2);
    chk(fault && fault_kind == 2'b10 && acc_cnt == 3 && wr_cnt == 0, "R5 rsv bit 5", {8'(acc_cnt), 8'(wr_cnt)}, {8'd3, 8'd0});
    chk(!mem_lock, "R5 lock released", mem_lock, 0);
    mem[DSC_A[10:3]] = ctl_w(32'h1, 8'h20, 0, 0) | (64'h1 << 24);
    send(16'd2);
    chk(fault && wr_cnt == 0, "R5 rsv bit 24", {fault, 8'(wr_cnt)}, {1'b1, 8'd0});
  endtask

  task automatic t_notify;
    logic [63:0] c0;
    c0 = ctl_w(32'h1234_5678, 8'h42, 0, 0);
    set_entry(1, 8'h01, 8'd5, DSC_A);
    mem[DSC_A[10:3]] = c0;
    mem[DSC_A[10:3] + 1] = 64'h1;
    x2_mode = 1'b0;
    send(16'd1);
    chk(done && acc_cnt == 6 && wr_cnt == 2, "R6 success sequence", {8'(acc_cnt), 8'(wr_cnt)}, {8'd6, 8'd2});
    chk(mem[DSC_A[10:3] + 1] == 64'h21, "R6 posted bit set", mem[DSC_A[10:3] + 1], 64'h21);
    chk(mem[DSC_A[10:3]] == (c0 | 64'h1), "R7 outstanding set", mem[DSC_A[10:3]], c0 | 64'h1);
    chk(ipi_valid && ipi_vec == 8'h42 && ipi_dst == 32'h56, "R8 short destination", {ipi_valid, ipi_vec, ipi_dst}, {1'b1, 8'h42, 32'h56});
    chk(lock_err == 0, "R9 lock during descriptor access", lock_err, 0);
    // outstanding already set: no notification, control unchanged
    set_entry(1, 8'h01, 8'd63, DSC_A);
    send(16'd1);
    chk(done && !ipi_valid, "R7 no notify when outstanding", ipi_valid, 0);
    chk(mem[DSC_A[10:3]] == (c0 | 64'h1) && mem[DSC_A[10:3] + 1] == 64'h8000_0000_0000_0021,
        "R7 words after repeat", mem[DSC_A[10:3] + 1], 64'h8000_0000_0000_0021);
    // suppress set
    mem[DSC_A[10:3]] = ctl_w(32'h1234_5678, 8'h42, 1, 0);
    send(16'd1);
    chk(done && !ipi_valid && mem[DSC_A[10:3]] == ctl_w(32'h1234_5678, 8'h42, 1, 0),
        "R7 suppress blocks notify", mem[DSC_A[10:3]], ctl_w(32'h1234_5678, 8'h42, 1, 0));
    // extended addressing
    mem[DSC_A[10:3]] = ctl_w(32'hCAFE_0102, 8'h77, 0, 0);
    x2_mode = 1'b1;
    send(16'd1);
    chk(ipi_valid && ipi_vec == 8'h77 && ipi_dst == 32'hCAFE_0102, "R8 full destination", ipi_dst, 32'hCAFE_0102);
    x2_mode = 1'b0;
    @(negedge clk);
    chk(!ipi_valid && !done && !mem_lock, "R9 R11 after completion", {ipi_valid, done, mem_lock}, 0);
  endtask

  task automatic t_busy;
    int d0, f0;
    set_entry(1, 8'h01, 8'd0, DSC_A);
    mem[DSC_A[10:3]] = ctl_w(32'h0000_1100, 8'h10, 0, 0);
    set_entry(0, 8'h00, 8'd1, DSC_B);
    d0 = done_cnt; f0 = fault_cnt;
    @(negedge clk);
    index = 16'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    index = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 30; k++) @(negedge clk);
    chk(done_cnt - d0 == 1 && fault_cnt == f0, "R11 start while busy ignored",
        {8'(done_cnt - d0), 8'(fault_cnt - f0)}, {8'd1, 8'd0});
    chk(sup_err == 0, "R10 supervisor marking", sup_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; index = '0; tbl_base = TBASE; tbl_size = 16'd3;
    x2_mode = 1'b0; first_seen = 1'b0; lat = 0;
    set_cfg(1, 1, 1, 0);
    for (int k = 0; k < 256; k++) mem[k] = 64'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_index();
    t_entry_bad();
    t_resv();
    t_notify();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule